// File: doc/BRIEF.md
# Early Effective Address Generator

This block computes the memory-operand address of the next instruction while the current instruction is still in its last cycle. The prefetch queue raises a pop strobe in the delay slot that follows the current instruction's run-next signal. In that cycle the block does three things. It picks the decoded base and index registers from the register file. It forwards the current instruction's write-back result into whichever of them it targets. It then forms the effective address and the segment-relocated linear address.

Both addresses are latched on the pop cycle. They are therefore stable during the first microcode cycle of the new instruction. An early read request is raised in that same cycle, so a load microinstruction can start its bus read at once, without a separate address step.

Forwarding takes the write width into account. The write-back value replaces only the bits that the current instruction writes. The other bits of the base or index operand keep their old register-file contents.

Top module: `early_ea_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs after that edge are all zero: `ea_q_o`, `lin_q_o` and `rd_req_o`.
- R2: On a rising edge with `pop_i` high, `ea_q_o` takes base + (index shifted left by `scale_i`) + `disp_i`, modulo 2^32. `scale_i` 00, 01, 10 and 11 mean a factor of 1, 2, 4 and 8.
- R3: On a rising edge with `pop_i` high, `lin_q_o` takes the new effective address plus `seg_base_i`, modulo 2^32.
- R4: On a rising edge with `pop_i` low, `ea_q_o` and `lin_q_o` keep their values, whatever the other inputs are.
- R5: `rd_req_o` is high for the cycle after an edge where `pop_i` and `mem_op_i` were both high. It is low after every other edge.
- R6: A base with `base_vld_i` low adds zero. An index with `idx_vld_i` low also adds zero, at any scale.
- R7: If `wb_vld_i` is high, `wb_dst_i` equals an operand's selector, and `wb_width_i` is 11 (dword), that operand is all 32 bits of `wb_data_i`. For example, register 0 = 100, a write-back of 116 to register 0, base 0 and displacement 4 give an address of 120.
- R8: With `wb_width_i` = 10 (word), a matching operand is the register-file bits 31:16 joined to `wb_data_i` bits 15:0.
- R9: With `wb_width_i` = 00 (low byte), a matching operand is the register-file bits 31:8 joined to `wb_data_i` bits 7:0.
- R10: With `wb_width_i` = 01 (high byte), a matching operand is the register-file bits 31:16 and 7:0, with `wb_data_i` bits 15:8 in between.
- R11: If `wb_vld_i` is low, or `wb_dst_i` matches neither selector, both operands come unchanged from `rf_flat_i`. Register k occupies bits 32k+31:32k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pop_i | input | 1 | Next instruction popped from the prefetch queue this cycle |
| mem_op_i | input | 1 | Next instruction has a memory operand |
| base_vld_i | input | 1 | Base register present |
| base_sel_i | input | 3 | Base register number |
| idx_vld_i | input | 1 | Index register present |
| idx_sel_i | input | 3 | Index register number |
| scale_i | input | 2 | Index shift amount (0 to 3) |
| disp_i | input | 32 | Displacement |
| rf_flat_i | input | 256 | Register-file contents, register k at bits 32k+31:32k |
| wb_vld_i | input | 1 | Write-back of current instruction valid this cycle |
| wb_dst_i | input | 3 | Write-back destination register |
| wb_width_i | input | 2 | Write width: 00 low byte, 01 high byte, 10 word, 11 dword |
| wb_data_i | input | 32 | Write-back value |
| seg_base_i | input | 32 | Segment base |
| ea_q_o | output | 32 | Latched effective address |
| lin_q_o | output | 32 | Latched linear address |
| rd_req_o | output | 1 | Early read request for the latched address |

## Verification
The assertions assume that the decoded selectors, displacement, segment base and write-back fields are settled before each rising edge. They also assume that `pop_i` marks exactly the cycles in which a new address must be latched. Nothing is assumed about the pop spacing. Back-to-back pops and long idle gaps are both legal, and the hold and read-request checks cover either case.

The stimulus changes inputs only on the falling edge. It mixes directed cases with random ones. The directed cases cover each write width, a destination that misses both selectors, and absent base or index registers. In about half of the random cases the write-back destination is steered onto the base or index selector, so that forwarding occurs often.

// File: rtl/early_ea_pkg.sv
package early_ea_pkg;

    // Write-back width codes; the bit positions merged for each are fixed.
    typedef enum logic [1:0] {
        WBW_BYTE_LO = 2'b00,
        WBW_BYTE_HI = 2'b01,
        WBW_WORD    = 2'b10,
        WBW_DWORD   = 2'b11
    } wb_width_e;

    // Forwarding decision for one operand
    typedef struct packed {
        logic      hit;
        wb_width_e width;
    } fwd_ctl_t;

    // Index scaling: the two-bit code is the left-shift amount.
    function automatic int unsigned scale_shift(input logic [1:0] code);
        return int'(unsigned'(code));
    endfunction

endpackage

// File: rtl/ea_operand_fwd.sv
module ea_operand_fwd
    import early_ea_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned SEL_W    = $clog2(NUM_REGS)
) (
    input  logic                       vld_i,
    input  logic [SEL_W-1:0]           sel_i,
    input  logic [NUM_REGS*DATA_W-1:0] rf_flat_i,
    input  logic                       wb_vld_i,
    input  logic [SEL_W-1:0]           wb_dst_i,
    input  logic [1:0]                 wb_width_i,
    input  logic [DATA_W-1:0]          wb_data_i,
    output logic [DATA_W-1:0]          opnd_o
);

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;

    logic [DATA_W-1:0] stale;
    logic [DATA_W-1:0] merged;
    fwd_ctl_t          ctl;

    always_comb begin
        stale     = rf_flat_i[int'(sel_i)*DATA_W +: DATA_W];
        ctl.hit   = wb_vld_i && (wb_dst_i == sel_i);
        ctl.width = wb_width_e'(wb_width_i);
    end

    always_comb begin
        merged = stale;
        unique case (ctl.width)
            WBW_BYTE_LO: merged[BYTE_W-1:0]      = wb_data_i[BYTE_W-1:0];
            WBW_BYTE_HI: merged[WORD_W-1:BYTE_W] = wb_data_i[WORD_W-1:BYTE_W];
            WBW_WORD:    merged[WORD_W-1:0]      = wb_data_i[WORD_W-1:0];
            WBW_DWORD:   merged                  = wb_data_i;
            default:     merged                  = stale;
        endcase
    end

    always_comb begin
        if (!vld_i)
            opnd_o = '0;
        else if (ctl.hit)
            opnd_o = merged;
        else
            opnd_o = stale;
    end

endmodule

// File: rtl/ea_sum.sv
module ea_sum
    import early_ea_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] index_i,
    input  logic [1:0]        scale_i,
    input  logic [DATA_W-1:0] disp_i,
    input  logic [DATA_W-1:0] seg_base_i,
    output logic [DATA_W-1:0] ea_o,
    output logic [DATA_W-1:0] lin_o
);

    logic [DATA_W-1:0] scaled;

    always_comb begin
        scaled = index_i << scale_shift(scale_i);
        ea_o   = base_i + scaled + disp_i;
        lin_o  = ea_o + seg_base_i;
    end

endmodule

// File: rtl/ea_capture.sv
module ea_capture #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_i,
    input  logic              mem_op_i,
    input  logic [DATA_W-1:0] ea_i,
    input  logic [DATA_W-1:0] lin_i,
    output logic [DATA_W-1:0] ea_q_o,
    output logic [DATA_W-1:0] lin_q_o,
    output logic              rd_req_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q_o   <= '0;
            lin_q_o  <= '0;
            rd_req_o <= 1'b0;
        end else begin
            rd_req_o <= pop_i && mem_op_i;
            if (pop_i) begin
                ea_q_o  <= ea_i;
                lin_q_o <= lin_i;
            end
        end
    end

endmodule

// File: rtl/early_ea_gen.sv
module early_ea_gen
    import early_ea_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned SEL_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pop_i,
    input  logic                       mem_op_i,
    input  logic                       base_vld_i,
    input  logic [SEL_W-1:0]           base_sel_i,
    input  logic                       idx_vld_i,
    input  logic [SEL_W-1:0]           idx_sel_i,
    input  logic [1:0]                 scale_i,
    input  logic [DATA_W-1:0]          disp_i,
    input  logic [NUM_REGS*DATA_W-1:0] rf_flat_i,
    input  logic                       wb_vld_i,
    input  logic [SEL_W-1:0]           wb_dst_i,
    input  logic [1:0]                 wb_width_i,
    input  logic [DATA_W-1:0]          wb_data_i,
    input  logic [DATA_W-1:0]          seg_base_i,
    output logic [DATA_W-1:0]          ea_q_o,
    output logic [DATA_W-1:0]          lin_q_o,
    output logic                       rd_req_o
);

    localparam int unsigned NUM_OPND = 2;   // 0: base, 1: index

    logic              opnd_vld [NUM_OPND];
    logic [SEL_W-1:0]  opnd_sel [NUM_OPND];
    logic [DATA_W-1:0] opnd_val [NUM_OPND];
    logic [DATA_W-1:0] ea_comb;
    logic [DATA_W-1:0] lin_comb;

    always_comb begin
        opnd_vld[0] = base_vld_i;
        opnd_sel[0] = base_sel_i;
        opnd_vld[1] = idx_vld_i;
        opnd_sel[1] = idx_sel_i;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        ea_operand_fwd #(
            .DATA_W   (DATA_W),
            .NUM_REGS (NUM_REGS),
            .SEL_W    (SEL_W)
        ) u_fwd (
            .vld_i      (opnd_vld[g]),
            .sel_i      (opnd_sel[g]),
            .rf_flat_i  (rf_flat_i),
            .wb_vld_i   (wb_vld_i),
            .wb_dst_i   (wb_dst_i),
            .wb_width_i (wb_width_i),
            .wb_data_i  (wb_data_i),
            .opnd_o     (opnd_val[g])
        );
    end

    ea_sum #(.DATA_W(DATA_W)) u_sum (
        .base_i     (opnd_val[0]),
        .index_i    (opnd_val[1]),
        .scale_i    (scale_i),
        .disp_i     (disp_i),
        .seg_base_i (seg_base_i),
        .ea_o       (ea_comb),
        .lin_o      (lin_comb)
    );

    ea_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .pop_i    (pop_i),
        .mem_op_i (mem_op_i),
        .ea_i     (ea_comb),
        .lin_i    (lin_comb),
        .ea_q_o   (ea_q_o),
        .lin_q_o  (lin_q_o),
        .rd_req_o (rd_req_o)
    );

endmodule

// File: rtl/early_ea_chk.sv
module early_ea_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              pop_i,
    input logic              mem_op_i,
    input logic              base_vld_i,
    input logic              idx_vld_i,
    input logic [DATA_W-1:0] disp_i,
    input logic [DATA_W-1:0] seg_base_i,
    input logic [DATA_W-1:0] ea_q_o,
    input logic [DATA_W-1:0] lin_q_o,
    input logic              rd_req_o
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ea_q_o == '0) && (lin_q_o == '0) && !rd_req_o);

    // R3
    lin_relocated_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |=> lin_q_o == ea_q_o + $past(seg_base_i));

    // R4
    hold_without_pop_chk: assert property (@(posedge clk) disable iff (rst)
        !pop_i |=> $stable(ea_q_o) && $stable(lin_q_o));

    // R5
    rd_req_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && mem_op_i) |=> rd_req_o);

    // R5
    rd_req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(pop_i && mem_op_i) |=> !rd_req_o);

    // R6
    null_operands_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !base_vld_i && !idx_vld_i) |=> ea_q_o == $past(disp_i));

endmodule

bind early_ea_gen early_ea_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pop_i      (pop_i),
    .mem_op_i   (mem_op_i),
    .base_vld_i (base_vld_i),
    .idx_vld_i  (idx_vld_i),
    .disp_i     (disp_i),
    .seg_base_i (seg_base_i),
    .ea_q_o     (ea_q_o),
    .lin_q_o    (lin_q_o),
    .rd_req_o   (rd_req_o)
);

// File: tb/early_ea_gen_tb.sv
module early_ea_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pop_i = 1'b0;
    logic        mem_op_i = 1'b0;
    logic        base_vld_i = 1'b0;
    logic [2:0]  base_sel_i = '0;
    logic        idx_vld_i = 1'b0;
    logic [2:0]  idx_sel_i = '0;
    logic [1:0]  scale_i = '0;
    logic [31:0] disp_i = '0;
    logic [255:0] rf_flat_i;
    logic        wb_vld_i = 1'b0;
    logic [2:0]  wb_dst_i = '0;
    logic [1:0]  wb_width_i = '0;
    logic [31:0] wb_data_i = '0;
    logic [31:0] seg_base_i = '0;
    logic [31:0] ea_q_o;
    logic [31:0] lin_q_o;
    logic        rd_req_o;

    logic [31:0] rf_m [8];

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 0;

    logic [31:0] exp_ea = '0;
    logic [31:0] exp_lin = '0;
    logic        exp_rd = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    always_comb begin
        for (int k = 0; k < 8; k++) rf_flat_i[k*32 +: 32] = rf_m[k];
    end

    early_ea_gen u_dut (
        .clk(clk), .rst(rst), .pop_i(pop_i), .mem_op_i(mem_op_i),
        .base_vld_i(base_vld_i), .base_sel_i(base_sel_i),
        .idx_vld_i(idx_vld_i), .idx_sel_i(idx_sel_i), .scale_i(scale_i),
        .disp_i(disp_i), .rf_flat_i(rf_flat_i), .wb_vld_i(wb_vld_i),
        .wb_dst_i(wb_dst_i), .wb_width_i(wb_width_i), .wb_data_i(wb_data_i),
        .seg_base_i(seg_base_i), .ea_q_o(ea_q_o), .lin_q_o(lin_q_o),
        .rd_req_o(rd_req_o)
    );

    // Operand value as the requirements define it
    function automatic logic [31:0] model_opnd(input logic v, input logic [2:0] s);
        logic [31:0] r;
        if (!v) return 32'd0;
        r = rf_m[s];
        if (wb_vld_i && wb_dst_i == s) begin
            case (wb_width_i)
                2'b00: r = {r[31:8], wb_data_i[7:0]};
                2'b01: r = {r[31:16], wb_data_i[15:8], r[7:0]};
                2'b10: r = {r[31:16], wb_data_i[15:0]};
                default: r = wb_data_i;
            endcase
        end
        return r;
    endfunction

    task automatic step(input string tag);
        logic [31:0] e;
        if (rst) begin
            exp_ea = '0; exp_lin = '0; exp_rd = 1'b0;
        end else begin
            exp_rd = pop_i && mem_op_i;
            if (pop_i) begin
                e = model_opnd(base_vld_i, base_sel_i)
                  + (model_opnd(idx_vld_i, idx_sel_i) * (32'd1 << scale_i))
                  + disp_i;
                exp_ea  = e;
                exp_lin = e + seg_base_i;
            end
        end
        @(posedge clk);
        @(negedge clk);
        vectors++;
        if (ea_q_o !== exp_ea || lin_q_o !== exp_lin || rd_req_o !== exp_rd) begin
            miscompares++;
            $display("FAIL %s: ea=%h lin=%h rd=%b expected ea=%h lin=%h rd=%b",
                     tag, ea_q_o, lin_q_o, rd_req_o, exp_ea, exp_lin, exp_rd);
        end
    endtask

    task automatic set_addr(input logic bv, input logic [2:0] bs, input logic iv,
                            input logic [2:0] is, input logic [1:0] sc,
                            input logic [31:0] d, input logic [31:0] sg);
        base_vld_i = bv; base_sel_i = bs; idx_vld_i = iv; idx_sel_i = is;
        scale_i = sc; disp_i = d; seg_base_i = sg;
    endtask

    task automatic set_wb(input logic v, input logic [2:0] dst, input logic [1:0] w,
                          input logic [31:0] data);
        wb_vld_i = v; wb_dst_i = dst; wb_width_i = w; wb_data_i = data;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) rf_m[k] = 32'h1111_0000 * (k + 1) + k;
        @(negedge clk);
        // R1: reset dominates even with pop active
        pop_i = 1'b1; mem_op_i = 1'b1;
        set_addr(1, 3'd2, 1, 3'd3, 2'd2, 32'h40, 32'h1000);
        step("R1");
        step("R1");
        rst = 1'b0;

        // R7: add eax,16 then mov ebx,[eax+4]
        rf_m[0] = 32'd100;
        set_addr(1, 3'd0, 0, 3'd0, 2'd0, 32'd4, 32'd0);
        set_wb(1, 3'd0, 2'b11, 32'd116);
        step("R7");
        if (ea_q_o !== 32'd120) begin
            miscompares++;
            $display("FAIL R7: ea=%0d expected 120", ea_q_o);
        end
        vectors++;

        // R8: word write into index
        rf_m[5] = 32'hAABB_CCDD;
        set_addr(0, 3'd0, 1, 3'd5, 2'd1, 32'h10, 32'h2000);
        set_wb(1, 3'd5, 2'b10, 32'h1234_5678);
        step("R8");
        // R9: low byte write into base
        set_addr(1, 3'd5, 0, 3'd0, 2'd0, 32'h0, 32'h0);
        set_wb(1, 3'd5, 2'b00, 32'hFFFF_FF9A);
        step("R9");
        // R10: high byte write into base and index together
        set_addr(1, 3'd5, 1, 3'd5, 2'd3, 32'h3, 32'h0);
        set_wb(1, 3'd5, 2'b01, 32'h0000_7E00);
        step("R10");
        // R11: write-back not valid
        set_wb(0, 3'd5, 2'b11, 32'hDEAD_BEEF);
        step("R11");
        // R11: destination misses both selectors
        set_addr(1, 3'd1, 1, 3'd2, 2'd1, 32'h8, 32'h0);
        set_wb(1, 3'd6, 2'b11, 32'hDEAD_BEEF);
        step("R11");
        // R6: null base and index, forwarding present
        set_addr(0, 3'd6, 0, 3'd6, 2'd3, 32'h0000_0777, 32'h10);
        step("R6");
        // R2: each scale factor
        for (int s = 0; s < 4; s++) begin
            set_addr(1, 3'd1, 1, 3'd4, s[1:0], 32'hFFFF_FFF0, 32'h0);
            set_wb(0, 3'd0, 2'b11, 32'h0);
            step("R2");
        end
        // R3: wrap-around segment add
        set_addr(1, 3'd7, 0, 3'd0, 2'd0, 32'h0, 32'hFFFF_FF00);
        step("R3");
        // R5: pop without memory operand
        mem_op_i = 1'b0;
        step("R5");
        // R4: hold across idle cycles with changing inputs
        pop_i = 1'b0; mem_op_i = 1'b1;
        set_addr(1, 3'd2, 1, 3'd3, 2'd2, 32'h5555, 32'h9999);
        step("R4");
        set_wb(1, 3'd2, 2'b11, 32'h1);
        step("R4");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            pop_i = ($urandom_range(3) != 0);
            mem_op_i = $urandom_range(1);
            set_addr($urandom_range(3) != 0, 3'($urandom_range(7)),
                     $urandom_range(3) != 0, 3'($urandom_range(7)),
                     2'($urandom_range(3)), $urandom, $urandom);
            set_wb($urandom_range(3) != 0, 3'($urandom_range(7)),
                   2'($urandom_range(3)), $urandom);
            case ($urandom_range(3))
                0: wb_dst_i = base_sel_i;
                1: wb_dst_i = idx_sel_i;
                default: ;
            endcase
            if ($urandom_range(15) == 0) rf_m[$urandom_range(7)] = $urandom;
            step("R2");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                miscompares++;
                $display("FAIL watchdog: cycles=%0d expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

endmodule